// File: doc/BRIEF.md
# Self-Clocked Serial Result Transmitter

This block is the output port of a converter that hands 20-bit results to a host over three wires. It produces its own serial clock. The only timing reference is the master clock. Every sample interval is a fixed frame of sixteen equal periods. Settling periods and computation periods alternate, and the frame opens with a settling period. The host controls delivery with an active-low chip select. The block looks at that select only at the opening cycle of each computation period. When the select is low there and an unread word is held, the block clocks the word out, most significant bit first.

A data-ready flag tells the host whether an unread word is waiting. The flag is low while a word is unread. It goes high once the word has been fully sent. If a new result is loaded over a word that has not been read, the flag gives a short high pulse before the new word takes over. A host that lifts chip select during a transfer makes the block stop after the bit in flight. The block then picks up at the next unsent bit in a later computation period. The serial clock and data outputs are meant for tri-state pad cells, so the block also drives an enable. When that enable is low, both serial outputs are in high impedance.

Top module: `srt_result_tx`

## Requirements
- R1: The frame is 1024 clock cycles long, counted from the first cycle after reset. It holds 16 periods of 64 cycles. Even-numbered periods (0, 2, …) are settling periods and odd-numbered periods are computation periods. `drive_en_o` is high only inside a computation period, and never in the first cycle of any period.
- R2: `cs_n` is sampled only at cycle 0 of a computation period. A transfer begins in the next cycle only if `cs_n` is low at that point and an unread word is held (`drdy_o` low). A low `cs_n` at any other cycle starts nothing.
- R3: The word is sent from bit 19 down to bit 0. Each bit takes two cycles: `sclk_o` is low in the first and high in the second. An uninterrupted word that starts at frame cycle 64 sends bit 19 in cycles 65–66 and bit 0 in cycles 103–104.
- R4: `sdata_o` changes only as `sclk_o` falls, and it holds steady while `sclk_o` is high.
- R5: In the cycle after the last bit's high phase, `drdy_o` goes high and `drive_en_o` goes low. `drdy_o` then stays high, and nothing more is sent, until the next word is loaded.
- R6: If `cs_n` is high at the end of a bit's high phase, the transfer stops after that bit. A later computation period in which `cs_n` is sampled low resumes with the next unsent bit.
- R7: `load_i` takes effect only in the last cycle of the frame (cycle 1023). A strobe in any other cycle changes neither the held word nor `drdy_o`.
- R8: A load while `drdy_o` is high replaces the word at once, and `drdy_o` is low from the next cycle.
- R9: A load while `drdy_o` is low (unread word) makes `drdy_o` high for exactly four cycles. After that `drdy_o` is low with the new word held, and the next transfer starts from bit 19.
- R10: During and right after reset, `drdy_o` is high, `drive_en_o` is low and `sclk_o` is high. `sclk_o` stays high whenever `drive_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| load_i | input | 1 | Result load strobe |
| data_i | input | 20 | Result word to load |
| sclk_o | output | 1 | Serial clock, idles high |
| sdata_o | output | 1 | Serial data, valid when sclk_o rises |
| drive_en_o | output | 1 | Pad enable; low puts sclk_o and sdata_o in high impedance |
| drdy_o | output | 1 | High when no unread word is held |

## Verification
Two events can land on the same clock edge: the host lifting chip select, and the block completing a bit (including the final bit). The bench provokes this by raising `cs_n` in the exact cycle that a chosen bit's high phase ends, and again in the low phase of a bit. It then judges the result with a receiver model that counts the bits taken on rising serial clock, checks that driving stops one cycle later, and checks that the bits sent after resuming join up to give the loaded word. A load over an unread, partly sent word is also checked, to confirm that the bit position goes back to the top bit.

// File: rtl/srt_pkg.sv
package srt_pkg;

   // Kind of period inside one sample frame
   typedef enum logic {
      SRT_SETTLE  = 1'b0,
      SRT_COMPUTE = 1'b1
   } srt_period_e;

   // Per-cycle timing marks produced by the frame timer
   typedef struct packed {
      logic in_compute;   // current period is a computation period
      logic cmp_start;    // first cycle of a computation period
      logic near_end;     // no room left in this period for another bit
      logic load_slot;    // final cycle of the frame
   } srt_tick_t;

   function automatic srt_period_e period_kind(input logic odd_period);
      return odd_period ? SRT_COMPUTE : SRT_SETTLE;
   endfunction

endpackage

// File: rtl/srt_frame_timer.sv
module srt_frame_timer
   import srt_pkg::*;
#(
   parameter int PERIOD_LEN  = 64,
   parameter int NUM_PERIODS = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   output srt_tick_t tick_o
);

   localparam int CYC_W = $clog2(PERIOD_LEN);
   localparam int PER_W = $clog2(NUM_PERIODS);
   localparam bit POW2  = (PERIOD_LEN == (1 << CYC_W)) && (NUM_PERIODS == (1 << PER_W));

   logic [CYC_W-1:0] cyc;
   logic [PER_W-1:0] per;

   generate
      if (POW2) begin : g_pow2
         // One wrapping counter; fields are slices of it
         logic [CYC_W+PER_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
         end
         assign cyc = cnt_q[CYC_W-1:0];
         assign per = cnt_q[CYC_W+PER_W-1:CYC_W];
      end else begin : g_generic
         // Separate cycle and period counters with explicit wrap
         logic [CYC_W-1:0] cyc_q;
         logic [PER_W-1:0] per_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cyc_q <= '0;
               per_q <= '0;
            end else if (cyc_q == CYC_W'(PERIOD_LEN-1)) begin
               cyc_q <= '0;
               per_q <= (per_q == PER_W'(NUM_PERIODS-1)) ? '0 : per_q + 1'b1;
            end else begin
               cyc_q <= cyc_q + 1'b1;
            end
         end
         assign cyc = cyc_q;
         assign per = per_q;
      end
   endgenerate

   srt_period_e kind;
   assign kind = period_kind(per[0]);

   always_comb begin
      tick_o.in_compute = (kind == SRT_COMPUTE);
      tick_o.cmp_start  = (kind == SRT_COMPUTE) && (cyc == '0);
      tick_o.near_end   = (cyc >= CYC_W'(PERIOD_LEN-2));
      tick_o.load_slot  = (per == PER_W'(NUM_PERIODS-1)) && (cyc == CYC_W'(PERIOD_LEN-1));
   end

   // Period boundaries: the counter returns to cycle 0 after the last cycle
   assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == CYC_W'(PERIOD_LEN-1)) |=> (cyc == '0));

endmodule

// File: rtl/srt_word_hold.sv
module srt_word_hold #(
   parameter int WORD_W        = 20,
   parameter int REPLACE_PULSE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_slot_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] data_i,
   input  logic              done_i,
   output logic [WORD_W-1:0] word_o,
   output logic              take_o,
   output logic              drdy_o
);

   localparam int PC_W = $clog2(REPLACE_PULSE+1);

   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] stage_q;
   logic [PC_W-1:0]   pc_q;
   logic              drdy_q;
   logic              accept;

   assign accept = load_slot_i && load_i && (pc_q == '0);
   // Held word changes on this edge: bit position must restart
   assign take_o = (pc_q == PC_W'(1)) || (accept && drdy_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         stage_q <= '0;
         pc_q    <= '0;
         drdy_q  <= 1'b1;
      end else if (pc_q != '0) begin
         pc_q <= pc_q - 1'b1;
         if (pc_q == PC_W'(1)) begin
            word_q <= stage_q;
            drdy_q <= 1'b0;
         end
      end else if (accept) begin
         if (drdy_q) begin
            word_q <= data_i;
            drdy_q <= 1'b0;
         end else begin
            stage_q <= data_i;
            drdy_q  <= 1'b1;
            pc_q    <= PC_W'(REPLACE_PULSE);
         end
      end else if (done_i) begin
         drdy_q <= 1'b1;
      end
   end

   assign word_o = word_q;
   assign drdy_o = drdy_q;

   assert_done_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> drdy_q);

   assert_fall_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drdy_q) |-> ($past(load_slot_i && load_i) || $past(pc_q == PC_W'(1))));

   assert_pulse_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !drdy_q) |=> (drdy_q && (pc_q == PC_W'(REPLACE_PULSE))));

endmodule

// File: rtl/srt_shifter.sv
module srt_shifter #(
   parameter int WORD_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              cmp_start_i,
   input  logic              near_end_i,
   input  logic              pending_i,
   input  logic              take_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              sclk_o,
   output logic              sdata_o,
   output logic              drive_en_o,
   output logic              done_o
);

   localparam int IDX_W = $clog2(WORD_W+1);

   logic             active_q;
   logic             half_q;     // 0: clock low phase, 1: clock high phase
   logic [IDX_W-1:0] idx_q;      // bits already sent
   logic [IDX_W-1:0] sel;
   logic             bit_done;
   logic             last_bit;

   assign bit_done = active_q && half_q;
   assign last_bit = (idx_q == IDX_W'(WORD_W-1));
   assign done_o   = bit_done && last_bit;
   assign sel      = IDX_W'(WORD_W-1) - idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         half_q   <= 1'b0;
         idx_q    <= '0;
      end else if (take_i) begin
         active_q <= 1'b0;
         half_q   <= 1'b0;
         idx_q    <= '0;
      end else if (active_q) begin
         if (!half_q) begin
            half_q <= 1'b1;
         end else begin
            half_q <= 1'b0;
            idx_q  <= idx_q + 1'b1;
            if (last_bit || cs_n || near_end_i) active_q <= 1'b0;
         end
      end else if (cmp_start_i && !cs_n && pending_i) begin
         active_q <= 1'b1;
         half_q   <= 1'b0;
      end
   end

   assign drive_en_o = active_q;
   assign sclk_o     = active_q ? half_q : 1'b1;
   assign sdata_o    = active_q ? word_i[sel] : 1'b0;

   assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_q) |-> $past(cmp_start_i && !cs_n && pending_i));

   assert_data_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && sclk_o) |-> $stable(sdata_o));

   assert_stop_after_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_done && cs_n) |=> !active_q);

   assert_clock_low_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_q) |-> !sclk_o);

endmodule

// File: rtl/srt_result_tx.sv
module srt_result_tx
   import srt_pkg::*;
#(
   parameter int WORD_W        = 20,
   parameter int PERIOD_LEN    = 64,
   parameter int NUM_PERIODS   = 16,
   parameter int REPLACE_PULSE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] data_i,
   output logic              sclk_o,
   output logic              sdata_o,
   output logic              drive_en_o,
   output logic              drdy_o
);

   initial begin
      assert (2*WORD_W + 2 <= PERIOD_LEN)
         else $error("word does not fit in one computation period");
      assert ((NUM_PERIODS >= 2) && (NUM_PERIODS % 2 == 0))
         else $error("period count must be even");
      assert ((REPLACE_PULSE >= 1) && (REPLACE_PULSE < PERIOD_LEN))
         else $error("replacement pulse length out of range");
   end

   srt_tick_t         tick;
   logic [WORD_W-1:0] word;
   logic              take;
   logic              done;
   logic              drdy;

   srt_frame_timer #(
      .PERIOD_LEN (PERIOD_LEN),
      .NUM_PERIODS(NUM_PERIODS)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick_o(tick)
   );

   srt_word_hold #(
      .WORD_W       (WORD_W),
      .REPLACE_PULSE(REPLACE_PULSE)
   ) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_slot_i(tick.load_slot),
      .load_i     (load_i),
      .data_i     (data_i),
      .done_i     (done),
      .word_o     (word),
      .take_o     (take),
      .drdy_o     (drdy)
   );

   srt_shifter #(
      .WORD_W(WORD_W)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (cs_n),
      .cmp_start_i(tick.cmp_start),
      .near_end_i (tick.near_end),
      .pending_i  (!drdy),
      .take_i     (take),
      .word_i     (word),
      .sclk_o     (sclk_o),
      .sdata_o    (sdata_o),
      .drive_en_o (drive_en_o),
      .done_o     (done)
   );

   assign drdy_o = drdy;

   assert_compute_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
      drive_en_o |-> tick.in_compute);

   assert_stop_on_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drive_en_o) |-> $past(sclk_o));

endmodule

// File: tb/srt_result_tx_test.sv
module srt_result_tx_test;

   localparam int FRAME = 1024;
   localparam int PLEN  = 64;
   localparam int NVEC  = 6;
   // {data[19:0], bits sent before chip select is raised (0 = no pause)}
   localparam logic [25:0] VECS [NVEC] = '{
      {20'hA5C3F, 6'd0},
      {20'h00001, 6'd0},
      {20'h80000, 6'd1},
      {20'hFFFFF, 6'd19},
      {20'h12345, 6'd7},
      {20'h6B1E0, 6'd10}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        load = 1'b0;
   logic [19:0] din = '0;
   logic        sclk, sdata, drive_en, drdy;

   int n_chk = 0;
   int n_bad = 0;
   int tcnt = 0;
   int rx_bits = 0;
   logic [63:0] rx_hist = '0;
   int mon_r1 = 0, mon_r4 = 0, mon_r10 = 0;
   logic prev_en = 1'b0, prev_sclk = 1'b1, prev_sdata = 1'b0;

   srt_result_tx uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .load_i(load), .data_i(din),
      .sclk_o(sclk), .sdata_o(sdata), .drive_en_o(drive_en), .drdy_o(drdy)
   );

   always #10 clk = ~clk;

   // Mirror of the frame position, equal to the cycle index at each falling edge
   always @(posedge clk) begin
      if (!rst_n) tcnt <= 0;
      else        tcnt <= tcnt + 1;
   end

   // Receiver model and continuous monitors
   always @(negedge clk) begin
      if (rst_n) begin
         if (drive_en && sclk && prev_en && !prev_sclk) begin
            rx_hist = {rx_hist[62:0], sdata};
            rx_bits = rx_bits + 1;
         end
         if (drive_en && ((((tcnt / PLEN) % 2) == 0) || ((tcnt % PLEN) == 0))) mon_r1++;
         if (drive_en && sclk && prev_en && (sdata !== prev_sdata)) mon_r4++;
         if (!drive_en && (sclk !== 1'b1)) mon_r10++;
      end
      prev_en    = drive_en;
      prev_sclk  = sclk;
      prev_sdata = sdata;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int c);
      do @(negedge clk); while ((tcnt % FRAME) != c);
   endtask

   // Strobe in the last frame cycle; returns in cycle 0 of the next frame
   task automatic do_load(input logic [19:0] d);
      wait_cyc(FRAME-1);
      load = 1'b1;
      din  = d;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic run_vec(input logic [19:0] d, input int p);
      int base;
      do_load(d);
      chk("R8 drdy low after load", 32'(drdy), 32'd0);
      base = rx_bits;
      cs_n = 1'b0;
      if (p == 0) begin
         wait_cyc(104);
         chk("R3 last bit high phase at cycle 104", {30'd0, drive_en, sclk}, 32'd3);
         chk("R3 drdy still low at 104", 32'(drdy), 32'd0);
         @(negedge clk);
         chk("R5 drdy high after lsb", 32'(drdy), 32'd1);
         chk("R5 driver off after lsb", 32'(drive_en), 32'd0);
         wait_cyc(193);
         chk("R5 no resend with cs low", 32'(drive_en), 32'd0);
         chk("R5 drdy held high", 32'(drdy), 32'd1);
      end else begin
         wait_cyc(64 + 2*p);
         cs_n = 1'b1;               // sampled at the edge ending this bit
         @(negedge clk);
         chk("R6 stop after current bit", 32'(drive_en), 32'd0);
         chk("R6 bits before pause", 32'(rx_bits - base), 32'(p));
         wait_cyc(150);
         cs_n = 1'b0;
         wait_cyc(191);
         chk("R2 cs low mid-period starts nothing", 32'(drive_en), 32'd0);
         @(negedge clk);
         chk("R2 not driving at sample cycle", 32'(drive_en), 32'd0);
         @(negedge clk);
         chk("R2 resume after sampled cs", 32'(drive_en), 32'd1);
         wait_cyc(192 + 2*(20-p) + 2);
         chk("R5 drdy high after resumed lsb", 32'(drdy), 32'd1);
      end
      chk("R3 bit count", 32'(rx_bits - base), 32'd20);
      chk("R6 received word", {12'd0, rx_hist[19:0]}, {12'd0, d});
      cs_n = 1'b1;
   endtask

   initial begin
      int base;
      repeat (3) @(negedge clk);
      chk("R10 reset drdy", 32'(drdy), 32'd1);
      chk("R10 reset drive", 32'(drive_en), 32'd0);
      chk("R10 reset sclk", 32'(sclk), 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 after reset", {29'd0, drdy, drive_en, sclk}, 32'b101);

      // R2: cs low with no word held starts nothing
      cs_n = 1'b0;
      wait_cyc(65);
      chk("R2 no word no transfer", 32'(drive_en), 32'd0);
      cs_n = 1'b1;

      for (int i = 0; i < NVEC; i++) run_vec(VECS[i][25:6], int'(VECS[i][5:0]));

      // R7: strobes outside the final cycle are ignored
      wait_cyc(500);
      load = 1'b1; din = 20'h5A5A5;
      @(negedge clk);
      load = 1'b0;
      chk("R7 mid-frame strobe ignored", 32'(drdy), 32'd1);
      wait_cyc(FRAME-2);
      load = 1'b1; din = 20'h3C3C3;
      @(negedge clk);
      load = 1'b0;
      chk("R7 strobe at 1022 ignored", 32'(drdy), 32'd1);
      @(negedge clk);
      chk("R7 drdy high into next frame", 32'(drdy), 32'd1);
      cs_n = 1'b0;
      wait_cyc(65);
      chk("R7 nothing loaded to send", 32'(drive_en), 32'd0);
      cs_n = 1'b1;

      // R9: replace a word that was never read
      do_load(20'hC0FFE);
      chk("R8 first word loaded", 32'(drdy), 32'd0);
      do_load(20'h4D2B7);
      chk("R9 pulse cycle 0", 32'(drdy), 32'd1);
      @(negedge clk); chk("R9 pulse cycle 1", 32'(drdy), 32'd1);
      @(negedge clk); chk("R9 pulse cycle 2", 32'(drdy), 32'd1);
      @(negedge clk); chk("R9 pulse cycle 3", 32'(drdy), 32'd1);
      @(negedge clk); chk("R9 low after pulse", 32'(drdy), 32'd0);
      base = rx_bits;
      cs_n = 1'b0;
      wait_cyc(106);
      chk("R9 replaced word count", 32'(rx_bits - base), 32'd20);
      chk("R9 replaced word value", {12'd0, rx_hist[19:0]}, {12'd0, 20'h4D2B7});
      cs_n = 1'b1;

      // R9 with a partly sent word; R6 with cs raised during a low phase
      do_load(20'h13579);
      base = rx_bits;
      cs_n = 1'b0;
      wait_cyc(73);                 // low phase of the fifth bit
      cs_n = 1'b1;
      wait_cyc(75);
      chk("R6 raised in low phase finishes bit", 32'(rx_bits - base), 32'd5);
      chk("R6 driver off", 32'(drive_en), 32'd0);
      do_load(20'hE8A61);
      chk("R9 pulse over partial word", 32'(drdy), 32'd1);
      base = rx_bits;
      cs_n = 1'b0;
      wait_cyc(104);
      chk("R9 restart from msb timing", 32'(drdy), 32'd0);
      @(negedge clk);
      chk("R9 done at 105", 32'(drdy), 32'd1);
      wait_cyc(107);
      chk("R9 full word after replace", 32'(rx_bits - base), 32'd20);
      chk("R9 word after replace", {12'd0, rx_hist[19:0]}, {12'd0, 20'hE8A61});
      cs_n = 1'b1;

      chk("R1 drive only in computation periods", 32'(mon_r1), 32'd0);
      chk("R4 data steady while clock high", 32'(mon_r4), 32'd0);
      chk("R10 clock idles high", 32'(mon_r10), 32'd0);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule